// File: doc/BRIEF.md
# Bus-Hold Request/Grant Controller

This controller decides who owns a microcontroller's external memory bus. An outside master asks for the bus by pulling an active-low hold input. The controller passes that input through a synchronizer and waits for the current external cycle to finish. It then grants the bus by pulling its active-low hold-acknowledge output. While the bus is granted, the address pins float and the control strobes are only weakly driven. When the outside master lets go of the hold input, the controller drops the acknowledge and drives the bus again.

While the bus is lent out, the controller can ask for it back with an active-low bus-request output. It does so when it has an external cycle waiting, or when an interrupt arrives that needs code from external memory. Interrupts are reported on an active-low interrupt-out signal. An interrupt is reported at once if code runs from internal memory. It is reported only after the hold ends if external memory is needed. If it arrives while a grant is pending, it is reported at once and kept until the hold ends. The whole function is gated by an enable that stands for the pins being set to their bus-hold role.

The controller has five states. IDLE: the controller owns the bus. GRANT_PENDING: a hold has been seen and the grant waits for a cycle boundary. HELD: the bus is granted. REQUESTING: the bus is granted and bus-request is asserted. RELEASE: the bus is taken back, lasting one cycle.

Its transitions are these. IDLE goes to GRANT_PENDING when the block is enabled and the synchronized hold is active. GRANT_PENDING goes back to IDLE if the hold is withdrawn or the block is disabled. GRANT_PENDING goes to HELD when no external cycle is in progress. HELD goes to REQUESTING on a pending external cycle, or on an interrupt while not running from internal memory. HELD and REQUESTING go to RELEASE when the synchronized hold is released. RELEASE always goes to IDLE.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While `rst` is high, and after it, all active-low outputs are 1 and `bus_float` and `ctrl_weak` are 0.
- R2: With `hold_en` low, a low `hold_req_n` never lowers `hold_ack_n`.
- R3: With `hold_en` high and `bus_cycle_active` low, `hold_ack_n` falls after the fourth rising clock edge that follows `hold_req_n` going low. This is two synchronizer stages, one edge into GRANT_PENDING and one into HELD.
- R4: No grant is given while `bus_cycle_active` is 1. Once it drops with the hold still requested, `hold_ack_n` falls after the next edge.
- R5: `bus_float` and `ctrl_weak` are 1 exactly when `hold_ack_n` is 0.
- R6: `hold_ack_n` and `bus_req_n` both return to 1 after the third edge following `hold_req_n` going high.
- R7: In HELD, `ext_pending` high makes `bus_req_n` 0 after the next edge. It stays 0, even if `ext_pending` drops, until the hold is released.
- R8: An `irq` pulse while the bus is granted and `run_internal` is 1 makes `int_out_n` 0 after the next edge, without asserting `bus_req_n`.
- R9: An `irq` pulse while the bus is granted and `run_internal` is 0 makes `bus_req_n` 0 after the next edge. `int_out_n` stays 1 until the RELEASE state and falls after the edge that leaves RELEASE (the fourth edge after `hold_req_n` rises).
- R10: An `irq` pulse in GRANT_PENDING makes `int_out_n` 0 after the next edge. It stays 0 until the hold is released, whatever `irq_ack` does meanwhile.
- R11: `irq_ack` clears `int_out_n` after the next edge only in IDLE, and it is ignored while the bus is granted. If `irq` and `irq_ack` are both high in IDLE, `int_out_n` stays 0.
- R12: `bus_req_n` is 0 only while `hold_ack_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transitions on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_en | input | 1 | Enables the bus-hold function (pins in their bus-hold role) |
| hold_req_n | input | 1 | Asynchronous hold request from the outside master, active low |
| bus_cycle_active | input | 1 | An external bus cycle is in progress (not a grant boundary) |
| ext_pending | input | 1 | An external bus cycle is waiting to start |
| run_internal | input | 1 | Code is executing from internal memory |
| irq | input | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_req_n | output | 1 | Request to get the bus back, active low |
| int_out_n | output | 1 | Interrupt indication, active low |
| bus_float | output | 1 | Tristate the address outputs |
| ctrl_weak | output | 1 | Drive the control strobes weakly |

## Verification
The assertions check on every cycle the relations that hold at all times. These are: the float and weak-drive outputs track the acknowledge, bus-request appears only inside a grant, a grant or release follows the hold input as it was three samples earlier, and no grant is made during an external cycle. They also check how an interrupt inside a grant is steered by `run_internal`. The exact latency of each transition, the sticky nature of re-requesting and of a window interrupt, and the rule that acknowledges are ignored until IDLE can only be shown by the bench's timed scenarios.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_GRANT_PENDING,
        S_HELD,
        S_REQUESTING,
        S_RELEASE
    } bhc_state_e;
endpackage

// File: rtl/bhc_sync.sv
// Multi-stage synchronizer for an active-low asynchronous input; output is active high.
module bhc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_n,
    output logic act
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], ~din_n};
    end

    assign act = sh_q[STAGES-1];
endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
    import bhc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold_en,
    input  logic hold_act,
    input  logic bus_cycle_active,
    input  logic ext_pending,
    input  logic irq,
    input  logic run_internal,
    output logic granted,
    output logic breq,
    output logic window,
    output logic releasing,
    output logic idle
);
    bhc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (hold_en && hold_act) state_d = S_GRANT_PENDING;
            S_GRANT_PENDING:
                if (!hold_act || !hold_en) state_d = S_IDLE;
                else if (!bus_cycle_active) state_d = S_HELD;
            S_HELD:
                if (!hold_act) state_d = S_RELEASE;
                else if (ext_pending || (irq && !run_internal)) state_d = S_REQUESTING;
            S_REQUESTING:
                if (!hold_act) state_d = S_RELEASE;
            S_RELEASE:
                state_d = S_IDLE;
            default:
                state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        granted   = 1'b0;
        breq      = 1'b0;
        window    = 1'b0;
        releasing = 1'b0;
        idle      = 1'b0;
        unique case (state_q)
            S_IDLE:          idle = 1'b1;
            S_GRANT_PENDING: window = 1'b1;
            S_HELD:          granted = 1'b1;
            S_REQUESTING: begin
                granted = 1'b1;
                breq    = 1'b1;
            end
            S_RELEASE:       releasing = 1'b1;
            default:         idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/bhc_irq.sv
// Interrupt-out gating: immediate, deferred to end of hold, or sticky in the grant window.
module bhc_irq (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic irq_ack,
    input  logic run_internal,
    input  logic granted,
    input  logic releasing,
    input  logic idle,
    output logic int_act
);
    logic defer_q;
    logic needs_ext;

    assign needs_ext = granted && !run_internal;

    always_ff @(posedge clk) begin
        if (rst) begin
            defer_q <= 1'b0;
            int_act <= 1'b0;
        end else begin
            if (irq && needs_ext)  defer_q <= 1'b1;
            else if (releasing)    defer_q <= 1'b0;

            if (irq && !needs_ext)         int_act <= 1'b1;
            else if (releasing && defer_q) int_act <= 1'b1;
            else if (idle && irq_ack)      int_act <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_en,
    input  logic hold_req_n,
    input  logic bus_cycle_active,
    input  logic ext_pending,
    input  logic run_internal,
    input  logic irq,
    input  logic irq_ack,
    output logic hold_ack_n,
    output logic bus_req_n,
    output logic int_out_n,
    output logic bus_float,
    output logic ctrl_weak
);
    logic hold_act;
    logic granted, breq, window, releasing, idle, int_act;

    bhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din_n (hold_req_n),
        .act   (hold_act)
    );

    bhc_fsm u_fsm (
        .clk              (clk),
        .rst              (rst),
        .hold_en          (hold_en),
        .hold_act         (hold_act),
        .bus_cycle_active (bus_cycle_active),
        .ext_pending      (ext_pending),
        .irq              (irq),
        .run_internal     (run_internal),
        .granted          (granted),
        .breq             (breq),
        .window           (window),
        .releasing        (releasing),
        .idle             (idle)
    );

    bhc_irq u_irq (
        .clk          (clk),
        .rst          (rst),
        .irq          (irq),
        .irq_ack      (irq_ack),
        .run_internal (run_internal),
        .granted      (granted),
        .releasing    (releasing),
        .idle         (idle),
        .int_act      (int_act)
    );

    assign hold_ack_n = ~granted;
    assign bus_req_n  = ~breq;
    assign int_out_n  = ~int_act;
    assign bus_float  = granted;
    assign ctrl_weak  = granted;
endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic hold_en,
    input logic hold_req_n,
    input logic bus_cycle_active,
    input logic ext_pending,
    input logic run_internal,
    input logic irq,
    input logic irq_ack,
    input logic hold_ack_n,
    input logic bus_req_n,
    input logic int_out_n,
    input logic bus_float,
    input logic ctrl_weak
);
    a_r5_float_weak: assert property (@(posedge clk) disable iff (rst)
        (bus_float == !hold_ack_n) && (ctrl_weak == !hold_ack_n));

    a_r12_breq_in_grant: assert property (@(posedge clk) disable iff (rst)
        !bus_req_n |-> !hold_ack_n);

    a_r2_disabled_no_grant: assert property (@(posedge clk) disable iff (rst)
        (!hold_en && hold_ack_n) |=> hold_ack_n);

    a_r3_grant_follows_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> !$past(hold_req_n, 3));

    a_r4_grant_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> !$past(bus_cycle_active));

    a_r6_release_follows_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_n) |-> ($past(hold_req_n, 3) && bus_req_n));

    a_r8_internal_irq_now: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack_n && irq && run_internal) |=> !int_out_n);

    a_r9_external_irq_deferred: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack_n && int_out_n && irq && !run_internal) |=> (int_out_n && !bus_req_n));
endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk u_chk (.*);

// File: tb/test_bus_hold_ctrl.sv
module test_bus_hold_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_en = 1'b1;
    logic hold_req_n = 1'b1;
    logic bus_cycle_active = 1'b0;
    logic ext_pending = 1'b0;
    logic run_internal = 1'b0;
    logic irq = 1'b0;
    logic irq_ack = 1'b0;
    logic hold_ack_n, bus_req_n, int_out_n, bus_float, ctrl_weak;

    bus_hold_ctrl i_bus_hold_ctrl (
        .clk(clk), .rst(rst), .hold_en(hold_en), .hold_req_n(hold_req_n),
        .bus_cycle_active(bus_cycle_active), .ext_pending(ext_pending),
        .run_internal(run_internal), .irq(irq), .irq_ack(irq_ack),
        .hold_ack_n(hold_ack_n), .bus_req_n(bus_req_n), .int_out_n(int_out_n),
        .bus_float(bus_float), .ctrl_weak(ctrl_weak)
    );

    always #10 clk = ~clk;

    // expected word: {hold_ack_n, bus_req_n, int_out_n, bus_float}
    typedef struct {
        int         cyc;
        logic [3:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int cyc = 0;
    int tests = 0;
    int fails = 0;
    exp_item_t it;
    logic [3:0] got;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares scoreboard items at the falling edge of their cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            it  = sb_q.pop_front();
            got = {hold_ack_n, bus_req_n, int_out_n, bus_float};
            tests++;
            if (it.cyc != cyc || got !== it.exp || ctrl_weak !== bus_float) begin
                fails++;
                $display("FAIL %s: got %b (weak %b) expected %b at cycle %0d",
                         it.tag, got, ctrl_weak, it.exp, it.cyc);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_at(input int dly, input logic [3:0] e, input string tag);
        exp_item_t x;
        x.cyc = cyc + dly;
        x.exp = e;
        x.tag = tag;
        sb_q.push_back(x);
    endtask

    localparam logic [3:0] IDLE_W = 4'b1110;
    localparam logic [3:0] HELD_W = 4'b0111;
    localparam logic [3:0] REQ_W  = 4'b0011;

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(1);
        expect_at(1, IDLE_W, "R1 in reset");
        tick(2);
        rst = 1'b0;
        expect_at(1, IDLE_W, "R1 after reset");
        tick(2);

        // R2: disabled
        hold_en = 1'b0;
        hold_req_n = 1'b0;
        expect_at(6, IDLE_W, "R2 hold ignored");
        tick(8);
        hold_req_n = 1'b1;
        tick(4);
        hold_en = 1'b1;

        // R3 / R5 / R6: plain grant and release
        hold_req_n = 1'b0;
        expect_at(3, IDLE_W, "R3 not yet");
        expect_at(4, HELD_W, "R3 R5 granted");
        tick(6);
        hold_req_n = 1'b1;
        expect_at(2, HELD_W, "R6 still held");
        expect_at(3, IDLE_W, "R6 released");
        tick(5);

        // R4: boundary
        bus_cycle_active = 1'b1;
        hold_req_n = 1'b0;
        expect_at(8, IDLE_W, "R4 held off");
        tick(10);
        bus_cycle_active = 1'b0;
        expect_at(1, HELD_W, "R4 granted at boundary");
        tick(3);

        // R7: re-request
        ext_pending = 1'b1;
        expect_at(1, REQ_W, "R7 request");
        tick(3);
        ext_pending = 1'b0;
        expect_at(1, REQ_W, "R7 sticky");
        tick(2);
        hold_req_n = 1'b1;
        expect_at(2, REQ_W, "R7 until release");
        expect_at(3, IDLE_W, "R6 R7 released");
        tick(5);

        // R8 / R11: internal-memory interrupt
        run_internal = 1'b1;
        hold_req_n = 1'b0;
        tick(6);
        irq = 1'b1;
        expect_at(1, 4'b0101, "R8 immediate");
        tick(1);
        irq = 1'b0;
        irq_ack = 1'b1;
        expect_at(1, 4'b0101, "R11 ack ignored in hold");
        tick(1);
        irq_ack = 1'b0;
        hold_req_n = 1'b1;
        expect_at(3, 4'b1100, "R8 kept after release");
        tick(5);
        irq_ack = 1'b1;
        expect_at(1, IDLE_W, "R11 cleared in idle");
        tick(1);
        irq_ack = 1'b0;
        tick(2);

        // R9: external-memory interrupt
        run_internal = 1'b0;
        hold_req_n = 1'b0;
        tick(6);
        irq = 1'b1;
        expect_at(1, REQ_W, "R9 bus request");
        tick(1);
        irq = 1'b0;
        expect_at(2, REQ_W, "R9 deferred");
        tick(3);
        hold_req_n = 1'b1;
        expect_at(3, IDLE_W, "R9 not in release");
        expect_at(4, 4'b1100, "R9 after release");
        tick(6);
        irq_ack = 1'b1;
        expect_at(1, IDLE_W, "R11 clear");
        tick(1);
        irq_ack = 1'b0;
        tick(2);

        // R10: window interrupt
        bus_cycle_active = 1'b1;
        hold_req_n = 1'b0;
        tick(5);
        irq = 1'b1;
        expect_at(1, 4'b1100, "R10 window");
        tick(1);
        irq = 1'b0;
        irq_ack = 1'b1;
        expect_at(1, 4'b1100, "R10 ack ignored");
        tick(1);
        irq_ack = 1'b0;
        hold_req_n = 1'b1;
        expect_at(4, 4'b1100, "R10 kept to idle");
        tick(5);
        bus_cycle_active = 1'b0;

        // R11: set wins over clear
        irq = 1'b1;
        irq_ack = 1'b1;
        expect_at(1, 4'b1100, "R11 set wins");
        tick(1);
        irq = 1'b0;
        expect_at(1, IDLE_W, "R11 clear");
        tick(1);
        irq_ack = 1'b0;
        tick(4);

        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule